// File: doc/BRIEF.md
# RC4-Compatible Stream Cipher Engine

This block applies an RC4-compatible keystream to a stream of 32-bit words. The host first writes the key bytes into a small key register file. It then pulses a start strobe together with a key length of 5 to 16 bytes. The block fills its 256-entry byte permutation with the identity pattern and runs the key-scheduling pass, one swap per clock. During this pass it reports busy and refuses data.

Once the pass is done, data words enter on a valid/ready input stream. Each word is split into four bytes and ciphered one byte per clock, most significant byte first. Each byte is XORed with the next keystream byte, and the four results are repacked into a word on a valid/ready output stream. The same operation and the same key turn ciphertext back into plaintext. The keystream indices carry over from word to word until a new key start.

Back-pressure rules:
- An input word is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high.
- `in_ready_o` is high only while no word is being ciphered.
- An output word is taken on an edge where `out_valid_o` and `out_ready_i` are both high.
- While `out_ready_i` stays low, the output word is held, and the following word stops before its last byte.

Top module: `rc4_stream_engine`

## Requirements
- R1: Each result byte is the input byte XOR the next RC4 keystream byte (standard key scheduling, then standard generation). Bytes are ciphered in the order `in_data_i[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, and each result stays at the bit position of its input byte.
- R2: The key byte written with `key_addr_i = k` is key byte k, where byte 0 is used first. The key length is taken from `key_len_i` at the start strobe. Values below 5 act as 5, and values above 16 act as 16.
- R3: One cycle after `key_start_i`, `busy_o` is high. It stays high for exactly 257 cycles: one initialisation cycle followed by 256 scheduling swaps.
- R4: `in_ready_o` is low while `busy_o` is high, and also from reset until the first key start.
- R5: While `out_valid_o` is high and `out_ready_i` is low, the output word and its valid stay unchanged. Words leave in the order they entered, and none is lost.
- R6: Key byte writes made while `busy_o` is high are ignored.
- R7: `key_start_i` drops any word in progress and any pending output. The next words then use the keystream from its first byte.
- R8: Feeding the ciphertext back in after a fresh start with the same key returns the original plaintext.
- R9: The keystream continues across consecutive words; it does not restart at each word.
- R10: After reset, `busy_o`, `in_ready_o` and `out_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| key_we_i | input | 1 | Key byte write strobe |
| key_addr_i | input | 4 | Key byte index |
| key_data_i | input | 8 | Key byte value |
| key_len_i | input | 5 | Key length in bytes, sampled at start |
| key_start_i | input | 1 | Start key scheduling; aborts current work |
| busy_o | output | 1 | Key scheduling in progress |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted when high with valid |
| in_data_i | input | 32 | Input word |
| out_valid_o | output | 1 | Result word valid |
| out_ready_i | input | 1 | Downstream accepts result word |
| out_data_o | output | 32 | Result word |

## Verification
All-zero plaintext with a 5-byte key and with a 16-byte key returns the raw keystream, which is compared with published vectors. This separates errors in key scheduling from errors in generation. All-ones and mixed plaintext words under the same key show that the XOR and the byte positions are right, and consecutive words show that the keystream state carries over. A 7-byte key with varied words is compared against a bench-side software model and then decrypted back to the plaintext. Out-of-range lengths, key writes during scheduling, a restart in the middle of a word, and a stalled output each probe one boundary rule.

// File: rtl/rc4_engine_pkg.sv
package rc4_engine_pkg;
  localparam int unsigned SYM_W  = 8;
  localparam int unsigned SBOX_N = 1 << SYM_W;
  localparam int unsigned SCHED_CYCLES = SBOX_N + 1;

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    PH_NOKEY,
    PH_INIT,
    PH_SCHED,
    PH_RUN
  } phase_e;
endpackage

// File: rtl/rc4_key_store.sv
module rc4_key_store
  import rc4_engine_pkg::*;
#(
  parameter int unsigned KEY_MIN = 5,
  parameter int unsigned KEY_MAX = 16,
  localparam int unsigned AW = $clog2(KEY_MAX),
  localparam int unsigned LW = $clog2(KEY_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  sym_t          wr_data_i,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          adv_i,
  output sym_t          key_byte_o
);
  sym_t          key_q [KEY_MAX];
  logic [AW-1:0] last_idx_q;
  logic [AW-1:0] last_idx_d;
  logic [AW-1:0] rd_idx_q;

  // clamp requested length into the supported window, store length-1
  always_comb begin
    if (len_i < LW'(KEY_MIN)) begin
      last_idx_d = AW'(KEY_MIN - 1);
    end else if (len_i > LW'(KEY_MAX)) begin
      last_idx_d = AW'(KEY_MAX - 1);
    end else begin
      last_idx_d = AW'(len_i - 1'b1);
    end
  end

  for (genvar k = 0; k < KEY_MAX; k++) begin : g_key_reg
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        key_q[k] <= '0;
      end else if (wr_en_i && (wr_addr_i == AW'(k))) begin
        key_q[k] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      last_idx_q <= AW'(KEY_MIN - 1);
      rd_idx_q   <= '0;
    end else if (start_i) begin
      last_idx_q <= last_idx_d;
      rd_idx_q   <= '0;
    end else if (adv_i) begin
      rd_idx_q <= (rd_idx_q == last_idx_q) ? '0 : rd_idx_q + 1'b1;
    end
  end

  assign key_byte_o = key_q[rd_idx_q];
endmodule

// File: rtl/rc4_sbox.sv
module rc4_sbox
  import rc4_engine_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic sched_i,
  input  logic gen_i,
  input  sym_t key_byte_i,
  output logic sched_last_o,
  output sym_t ks_byte_o
);
  sym_t s_q [SBOX_N];
  sym_t i_q, j_q;
  sym_t i_nx, j_nx, si, sj, sum;
  logic step;

  assign step = sched_i || gen_i;

  // one swap per cycle: read both entries, write them crossed
  always_comb begin
    i_nx = gen_i ? i_q + 8'd1 : i_q;
    si   = s_q[i_nx];
    j_nx = gen_i ? j_q + si : j_q + si + key_byte_i;
    sj   = s_q[j_nx];
    sum  = si + sj;
    // keystream byte seen after the swap, forwarded from this cycle's writes
    if (sum == i_nx) begin
      ks_byte_o = sj;
    end else if (sum == j_nx) begin
      ks_byte_o = si;
    end else begin
      ks_byte_o = s_q[sum];
    end
  end

  for (genvar k = 0; k < SBOX_N; k++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (!rst_ni || init_i) begin
        s_q[k] <= sym_t'(k);
      end else if (step) begin
        if (i_nx == sym_t'(k)) begin
          s_q[k] <= sj;
        end else if (j_nx == sym_t'(k)) begin
          s_q[k] <= si;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || init_i) begin
      i_q <= '0;
      j_q <= '0;
    end else if (sched_i) begin
      if (sched_last_o) begin
        i_q <= '0;
        j_q <= '0;
      end else begin
        i_q <= i_q + 8'd1;
        j_q <= j_nx;
      end
    end else if (gen_i) begin
      i_q <= i_nx;
      j_q <= j_nx;
    end
  end

  assign sched_last_o = (i_q == '1);
endmodule

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
  import rc4_engine_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NB = DATA_W / SYM_W,
  localparam int unsigned CW = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_start_i,
  input  logic              sched_last_i,
  input  sym_t              ks_byte_i,
  output logic              init_o,
  output logic              sched_o,
  output logic              gen_o,
  output logic              busy_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  phase_e            ph_q;
  logic              work_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic [DATA_W-1:0] out_q;
  logic              out_v_q;
  logic              last_byte;
  logic              slot_free;
  sym_t              res_byte;

  assign last_byte  = (cnt_q == CW'(NB - 1));
  assign slot_free  = !out_v_q || out_ready_i;
  assign init_o     = (ph_q == PH_INIT);
  assign sched_o    = (ph_q == PH_SCHED);
  assign busy_o     = init_o || sched_o;
  assign in_ready_o = (ph_q == PH_RUN) && !work_q;
  // the last byte waits until the output slot can take the finished word
  assign gen_o      = (ph_q == PH_RUN) && work_q && (!last_byte || slot_free);

  assign res_byte = src_q[DATA_W-1 -: SYM_W] ^ ks_byte_i;
  assign acc_d    = {acc_q[DATA_W-SYM_W-1:0], res_byte};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q    <= PH_NOKEY;
      work_q  <= 1'b0;
      cnt_q   <= '0;
      src_q   <= '0;
      acc_q   <= '0;
      out_q   <= '0;
      out_v_q <= 1'b0;
    end else if (key_start_i) begin
      ph_q    <= PH_INIT;
      work_q  <= 1'b0;
      cnt_q   <= '0;
      out_v_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_INIT:  ph_q <= PH_SCHED;
        PH_SCHED: if (sched_last_i) ph_q <= PH_RUN;
        default:  ;
      endcase
      if (in_valid_i && in_ready_o) begin
        work_q <= 1'b1;
        src_q  <= in_data_i;
        cnt_q  <= '0;
      end
      if (out_v_q && out_ready_i) begin
        out_v_q <= 1'b0;
      end
      if (gen_o) begin
        src_q <= {src_q[DATA_W-SYM_W-1:0], {SYM_W{1'b0}}};
        acc_q <= acc_d;
        cnt_q <= cnt_q + 1'b1;
        if (last_byte) begin
          cnt_q   <= '0;
          work_q  <= 1'b0;
          out_q   <= acc_d;
          out_v_q <= 1'b1;
        end
      end
    end
  end

  assign out_valid_o = out_v_q;
  assign out_data_o  = out_q;
endmodule

// File: rtl/rc4_stream_engine.sv
module rc4_stream_engine
  import rc4_engine_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned KEY_MIN_BYTES = 5,
  parameter int unsigned KEY_MAX_BYTES = 16,
  localparam int unsigned KEY_AW = $clog2(KEY_MAX_BYTES),
  localparam int unsigned KEY_LW = $clog2(KEY_MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [KEY_AW-1:0] key_addr_i,
  input  logic [SYM_W-1:0]  key_data_i,
  input  logic [KEY_LW-1:0] key_len_i,
  input  logic              key_start_i,
  output logic              busy_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);
  logic init_w, sched_w, gen_w, sched_last_w, busy_w;
  sym_t key_byte_w, ks_byte_w;

  rc4_key_store #(
    .KEY_MIN(KEY_MIN_BYTES),
    .KEY_MAX(KEY_MAX_BYTES)
  ) key_store_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (key_we_i && !busy_w),
    .wr_addr_i  (key_addr_i),
    .wr_data_i  (key_data_i),
    .start_i    (key_start_i),
    .len_i      (key_len_i),
    .adv_i      (sched_w),
    .key_byte_o (key_byte_w)
  );

  rc4_sbox sbox_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init_w),
    .sched_i      (sched_w),
    .gen_i        (gen_w),
    .key_byte_i   (key_byte_w),
    .sched_last_o (sched_last_w),
    .ks_byte_o    (ks_byte_w)
  );

  rc4_ctrl #(
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_start_i  (key_start_i),
    .sched_last_i (sched_last_w),
    .ks_byte_i    (ks_byte_w),
    .init_o       (init_w),
    .sched_o      (sched_w),
    .gen_o        (gen_w),
    .busy_o       (busy_w),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .in_data_i    (in_data_i),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o)
  );

  assign busy_o = busy_w;
endmodule

// File: rtl/rc4_stream_engine_chk.sv
module rc4_stream_engine_chk
  import rc4_engine_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_start_i,
  input logic              busy_o,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o
);
  logic [9:0] busy_run_q;
  logic       key_seen_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_run_q <= '0;
      key_seen_q <= 1'b0;
    end else begin
      if (key_start_i) begin
        busy_run_q <= '0;
        key_seen_q <= 1'b1;
      end else if (busy_o) begin
        busy_run_q <= busy_run_q + 10'd1;
      end
    end
  end

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o |-> !in_ready_o); // R4
  AST_NO_INPUT_BEFORE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni) !key_seen_q |-> !in_ready_o); // R4
  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) key_start_i |=> busy_o); // R3
  AST_SCHED_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> (busy_run_q == 10'(SCHED_CYCLES))); // R3
  AST_START_DROPS_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni) key_start_i |=> !out_valid_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (out_valid_o && !out_ready_i && !key_start_i) |=> (out_valid_o && $stable(out_data_o))); // R5
endmodule

bind rc4_stream_engine rc4_stream_engine_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/rc4_stream_engine_tb_top.sv
module rc4_stream_engine_tb_top;
  import rc4_engine_pkg::*;

  typedef struct packed {
    logic         nk;
    logic [4:0]   len;
    logic [127:0] key;
    logic [31:0]  pt;
    logic [31:0]  ct;
  } vec_t;

  localparam logic [127:0] K40  = 128'h01020304_05000000_00000000_00000000;
  localparam logic [127:0] K128 = 128'h01020304_05060708_090a0b0c_0d0e0f10;
  localparam logic [127:0] K56  = 128'h1f2e3d4c_5b6a79aa_bbccddee_ff001122;

  // published keystream prefixes; all-ones / mixed words XORed in by hand
  localparam vec_t VECS [8] = '{
    {1'b1, 5'd5,  K40,  32'h00000000, 32'hb2396305},
    {1'b0, 5'd5,  K40,  32'hffffffff, 32'h0fc23fd8},
    {1'b0, 5'd5,  K40,  32'h12345678, 32'hdef70432},
    {1'b0, 5'd5,  K40,  32'h00000000, 32'h0a1118a8},
    {1'b1, 5'd16, K128, 32'h00000000, 32'h9ac7cc9a},
    {1'b0, 5'd16, K128, 32'h00000000, 32'h609d1ef7},
    {1'b0, 5'd16, K128, 32'h00000000, 32'hb2932899},
    {1'b0, 5'd16, K128, 32'h00000000, 32'hcde41b97}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        key_we_i, key_start_i, in_valid_i, out_ready_i;
  logic [3:0]  key_addr_i;
  logic [7:0]  key_data_i;
  logic [4:0]  key_len_i;
  logic [31:0] in_data_i, out_data_o;
  logic        busy_o, in_ready_o, out_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mks [64];

  always #5 clk_i = ~clk_i;

  rc4_stream_engine dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_key(input logic [127:0] key);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk_i);
      key_we_i = 1'b1; key_addr_i = 4'(k); key_data_i = key[127-8*k -: 8];
    end
    @(negedge clk_i);
    key_we_i = 1'b0;
  endtask

  task automatic start_key(input logic [4:0] len);
    key_len_i = len; key_start_i = 1'b1;
    @(negedge clk_i);
    key_start_i = 1'b0;
  endtask

  task automatic wait_ready();
    while (!in_ready_o) @(negedge clk_i);
  endtask

  task automatic send_word(input logic [31:0] d);
    in_valid_i = 1'b1; in_data_i = d;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic recv_word(output logic [31:0] d);
    while (!out_valid_o) @(negedge clk_i);
    d = out_data_o;
    @(negedge clk_i);
  endtask

  task automatic rc4_model(input logic [127:0] key, input int len, input int n);
    logic [7:0] s [256];
    logic [7:0] t;
    int i, j;
    for (int k = 0; k < 256; k++) s[k] = 8'(k);
    j = 0;
    for (int k = 0; k < 256; k++) begin
      j = (j + int'(s[k]) + int'(key[127-8*(k%len) -: 8])) % 256;
      t = s[k]; s[k] = s[j]; s[j] = t;
    end
    i = 0; j = 0;
    for (int m = 0; m < n; m++) begin
      i = (i + 1) % 256;
      j = (j + int'(s[i])) % 256;
      t = s[i]; s[i] = s[j]; s[j] = t;
      mks[m] = s[(int'(s[i]) + int'(s[j])) % 256];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, got2;
    logic [31:0] pt [6];
    logic [31:0] ct [6];
    int n;
    bit bad;
    rst_ni = 1'b0; key_we_i = 0; key_start_i = 0; in_valid_i = 0; out_ready_i = 1'b1;
    key_addr_i = '0; key_data_i = '0; key_len_i = 5'd5; in_data_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk("R10 busy", 32'(busy_o), 0);
    chk("R10 in_ready", 32'(in_ready_o), 0);
    chk("R10 out_valid", 32'(out_valid_o), 0);

    // R4 no acceptance before any key
    bad = 0;
    in_valid_i = 1'b1;
    repeat (5) begin @(negedge clk_i); if (in_ready_o) bad = 1; end
    in_valid_i = 1'b0;
    chk("R4 ready before key", 32'(bad), 0);

    // R3 scheduling length, R4 ready after
    write_key(K40);
    start_key(5'd5);
    chk("R3 busy after start", 32'(busy_o), 1);
    chk("R4 no ready while busy", 32'(in_ready_o), 0);
    n = 0;
    while (busy_o) begin n++; @(negedge clk_i); end
    chk("R3 busy cycles", 32'(n), 32'd257);
    chk("R4 ready after schedule", 32'(in_ready_o), 1);

    // R1 / R9 vector table
    for (int v = 0; v < 8; v++) begin
      if (VECS[v].nk) begin
        write_key(VECS[v].key);
        start_key(VECS[v].len);
        wait_ready();
      end
      send_word(VECS[v].pt);
      recv_word(got);
      chk($sformatf("R1 R9 vector %0d", v), got, VECS[v].ct);
    end

    // R2 length clamp below and above
    write_key(K40 | 128'h00000000_00aa5533_77889911_22334455);
    start_key(5'd2);
    wait_ready();
    send_word(32'h0); recv_word(got);
    chk("R2 short length clamps to 5", got, 32'hb2396305);
    write_key(K128);
    start_key(5'd31);
    wait_ready();
    send_word(32'h0); recv_word(got);
    chk("R2 long length clamps to 16", got, 32'h9ac7cc9a);

    // R6 key write during busy ignored
    write_key(K40);
    start_key(5'd5);
    @(negedge clk_i);
    key_we_i = 1'b1; key_addr_i = 4'd0; key_data_i = 8'hff;
    @(negedge clk_i);
    key_we_i = 1'b0;
    wait_ready();
    send_word(32'h0); recv_word(got);
    chk("R6 first run after busy write", got, 32'hb2396305);
    start_key(5'd5);
    wait_ready();
    send_word(32'h0); recv_word(got);
    chk("R6 key store unchanged", got, 32'hb2396305);

    // R7 abort a word in progress
    send_word(32'h0);
    key_len_i = 5'd5; key_start_i = 1'b1;
    @(negedge clk_i);
    key_start_i = 1'b0;
    chk("R7 busy after abort", 32'(busy_o), 1);
    bad = 0;
    while (!in_ready_o) begin if (out_valid_o) bad = 1; @(negedge clk_i); end
    chk("R7 aborted word not emitted", 32'(bad | out_valid_o), 0);
    send_word(32'h0); recv_word(got);
    chk("R7 keystream restarted", got, 32'hb2396305);

    // R5 back-pressure
    write_key(K128);
    start_key(5'd16);
    wait_ready();
    out_ready_i = 1'b0;
    send_word(32'h0);
    send_word(32'h0);
    bad = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (!out_valid_o || out_data_o !== 32'h9ac7cc9a || in_ready_o) bad = 1;
    end
    chk("R5 output held under stall", 32'(bad), 0);
    out_ready_i = 1'b1;
    recv_word(got);
    recv_word(got2);
    chk("R5 first word after stall", got, 32'h9ac7cc9a);
    chk("R5 second word in order", got2, 32'h609d1ef7);

    // R1 model comparison and R8 round trip, 7-byte key
    rc4_model(K56, 7, 24);
    for (int w = 0; w < 6; w++) pt[w] = 32'h9e3779b9 * 32'(w + 1) ^ 32'h0f1e2d3c;
    write_key(K56);
    start_key(5'd7);
    wait_ready();
    bad = 0;
    for (int w = 0; w < 6; w++) begin
      send_word(pt[w]); recv_word(ct[w]);
      if (ct[w] !== (pt[w] ^ {mks[4*w], mks[4*w+1], mks[4*w+2], mks[4*w+3]})) bad = 1;
    end
    chk("R1 seven-byte key vs model", 32'(bad), 0);
    start_key(5'd7);
    wait_ready();
    for (int w = 0; w < 6; w++) begin
      send_word(ct[w]); recv_word(got);
      chk($sformatf("R8 round trip word %0d", w), got, pt[w]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule